// File: doc/BRIEF.md
# Three-Level Clamped Leg Deadtime Sequencer

This block drives the four gate signals of one leg of a three-level neutral-point-clamped inverter. A modulator presents a two-bit level request every clock (0 = lower rail, 1 = neutral, 2 = upper rail). The block turns each request into a safe switching sequence. On every level change it first opens the switch that must stop conducting. It then holds the leg in a shared intermediate state for a programmable number of clock cycles. Only after that does it close the switch that must start conducting.

The leg may only move between neighbouring levels. A request across the whole range is carried out as two neighbouring steps through the neutral level, and each step gets its own deadtime. A request that arrives while a step is in progress is captured, and the latest valid request is served once the step is complete. The block reports whether a transition is in flight and which level the leg has settled at.

Top module: `npc_leg_dt`

## Requirements
- R1: After synchronous reset, gates = 4'b0110 (SW2 and SW3 on), `leg_level` = 1 and `busy` = 0.
- R2: Bit k of `gate` drives switch SW(k+1). A settled level 2 gives 4'b0011, level 1 gives 4'b0110 and level 0 gives 4'b1100.
- R3: SW1 and SW3 are never on together, and SW2 and SW4 are never on together. SW1 on implies SW2 on, and SW4 on implies SW3 on.
- R4: One clock edge after a valid request that differs from the settled level is sampled, `busy` rises and the gates show only the switch common to both levels. That switch is SW2 (4'b0010) for a 1↔2 step and SW3 (4'b0100) for a 0↔1 step.
- R5: The intermediate state lasts exactly D cycles, where D = `dead_cycles`, or 1 when `dead_cycles` = 0. After that, the new level's pattern appears, `busy` falls and `leg_level` takes the new level.
- R6: A 0↔2 request is executed as two adjacent steps, each with a full deadtime. Level 1 is shown settled for one cycle between the two steps.
- R7: Requests seen while `busy` is high are captured, and the most recent valid one is applied after the current step ends.
- R8: Request code 3 is ignored. The leg and the captured request keep their values.
- R9: `dead_cycles` is sampled when a step starts. Changing it during a step does not alter that step's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dead_cycles | input | DT_W | Deadtime length in clock cycles |
| level_req | input | 2 | Requested level code (0, 1, 2; 3 ignored) |
| gate | output | 4 | Gate drives, bit 0 = SW1 … bit 3 = SW4 |
| busy | output | 1 | A deadtime step is in progress |
| leg_level | output | 2 | Last settled level |

## Verification
The assertions check the following on every cycle:
- no complementary switch pair is ever on together;
- exactly one switch is on during deadtime and exactly two when settled;
- each completed step moves the level by exactly one;
- the timer counts down cycle by cycle.

The cycle-exact lengths of the deadtime, the two-step crossing with its single neutral cycle, the latest-request-wins capture, the ignored code 3 and the sampling of the deadtime value are shown only by the bench. It shows them by comparing the block against its behavioural model on every clock.

// File: rtl/npc_dt_pkg.sv
package npc_dt_pkg;
  typedef enum logic {PH_HOLD, PH_DEAD} phase_e;

  localparam logic [1:0] LVL_LO  = 2'd0;
  localparam logic [1:0] LVL_MID = 2'd1;
  localparam logic [1:0] LVL_HI  = 2'd2;

  // bit 0 = SW1 ... bit 3 = SW4
  function automatic logic [3:0] level_gates(input logic [1:0] lvl);
    case (lvl)
      LVL_HI:  return 4'b0011;
      LVL_MID: return 4'b0110;
      LVL_LO:  return 4'b1100;
      default: return 4'b0110;
    endcase
  endfunction

  // switch kept on while moving between two neighbouring levels
  function automatic logic [3:0] common_gates(input logic [1:0] a, input logic [1:0] b);
    return level_gates(a) & level_gates(b);
  endfunction
endpackage

// File: rtl/npc_req_latch.sv
module npc_req_latch
  import npc_dt_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] req,
  output logic [LVL_W-1:0] eff
);
  logic [LVL_W-1:0] held_q;

  // code above the top level is not a level: keep what was held (R8)
  always_comb eff = (req > LVL_HI) ? held_q : req;

  always_ff @(posedge clk) begin
    if (rst) held_q <= LVL_MID;
    else     held_q <= eff;
  end

  p_held_legal_r8: assert property (@(posedge clk) disable iff (rst)
    held_q <= LVL_HI);
endmodule

// File: rtl/npc_dt_timer.sv
module npc_dt_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  always_comb expire = (cnt_q == '0);

  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/npc_leg_dt.sv
module npc_leg_dt
  import npc_dt_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DT_W-1:0] dead_cycles,
  input  logic [1:0]      level_req,
  output logic [3:0]      gate,
  output logic            busy,
  output logic [1:0]      leg_level
);
  phase_e     phase_q;
  logic [1:0] cur_q, nxt_q, step_to, want;
  logic [3:0] gate_q;
  logic       start, expire;

  npc_req_latch #(.LVL_W(2)) u_req (
    .clk(clk), .rst(rst), .req(level_req), .eff(want)
  );

  always_comb begin
    start   = (phase_q == PH_HOLD) && (want != cur_q);
    step_to = (want > cur_q) ? cur_q + 2'd1 : cur_q - 2'd1;
  end

  npc_dt_timer #(.W(DT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(start), .load_val(dead_cycles),
    .run(phase_q == PH_DEAD), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_HOLD;
      cur_q   <= LVL_MID;
      nxt_q   <= LVL_MID;
      gate_q  <= level_gates(LVL_MID);
    end else if (start) begin
      phase_q <= PH_DEAD;
      nxt_q   <= step_to;
      gate_q  <= common_gates(cur_q, step_to);
    end else if (phase_q == PH_DEAD && expire) begin
      phase_q <= PH_HOLD;
      cur_q   <= nxt_q;
      gate_q  <= level_gates(nxt_q);
    end
  end

  assign gate      = gate_q;
  assign busy      = (phase_q == PH_DEAD);
  assign leg_level = cur_q;

  p_no_upper_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(gate[0] && gate[2]));
  p_no_lower_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(gate[1] && gate[3]));
  p_clamp_order_r3: assert property (@(posedge clk) disable iff (rst)
    (!gate[0] || gate[1]) && (!gate[3] || gate[2]));
  p_dead_single_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> $countones(gate) == 1);
  p_settled_pair_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> $countones(gate) == 2);
  p_step_adjacent_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (leg_level == $past(leg_level) + 2'd1) || (leg_level + 2'd1 == $past(leg_level)));
  p_level_stable_in_dead_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(leg_level));
endmodule

// File: tb/sim_npc_leg_dt.sv
module sim_npc_leg_dt;
  localparam int CLK_PERIOD = 10;
  localparam int DT_W = 8;

  logic            clk = 0;
  logic            rst = 1;
  logic [DT_W-1:0] dead_cycles = 8'd3;
  logic [1:0]      level_req = 2'd1;
  logic [3:0]      gate;
  logic            busy;
  logic [1:0]      leg_level;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  npc_leg_dt #(.DT_W(DT_W)) u0 (
    .clk(clk), .rst(rst), .dead_cycles(dead_cycles), .level_req(level_req),
    .gate(gate), .busy(busy), .leg_level(leg_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] pat(input int l);
    if (l == 2) return 4'b0011;
    if (l == 1) return 4'b0110;
    return 4'b1100;
  endfunction

  // behavioural reference model
  int m_cur = 1, m_nxt = 1, m_pend = 1, m_rem = 0;
  bit m_busy = 0;
  logic [3:0] m_gate = 4'b0110;

  always @(posedge clk) begin
    if (rst) begin
      m_cur = 1; m_nxt = 1; m_pend = 1; m_rem = 0; m_busy = 0; m_gate = pat(1);
    end else begin
      int eff;
      eff = (level_req == 2'd3) ? m_pend : int'(level_req);
      if (!m_busy) begin
        if (eff != m_cur) begin
          m_nxt  = (eff > m_cur) ? m_cur + 1 : m_cur - 1;
          m_busy = 1;
          m_rem  = (dead_cycles == 0) ? 1 : int'(dead_cycles);
          m_gate = pat(m_cur) & pat(m_nxt);
        end
      end else begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin
          m_cur = m_nxt; m_busy = 0; m_gate = pat(m_cur);
        end
      end
      m_pend = eff;
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (gate !== m_gate || busy !== m_busy || leg_level !== 2'(m_cur)) begin
      errors++;
      $display("FAIL %s: gate=%b busy=%b level=%0d expected gate=%b busy=%b level=%0d",
               tag, gate, busy, leg_level, m_gate, m_busy, m_cur);
    end
    checks++; // R3 overlap check
    if ((gate[0] && gate[2]) || (gate[1] && gate[3])) begin
      errors++;
      $display("FAIL R3: gate=%b expected no complementary overlap", gate);
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [1:0] req, input int n, input string t);
    @(negedge clk);
    tag = t;
    level_req = req;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (gate !== 4'b0110 || busy !== 1'b0 || leg_level !== 2'd1) begin
      errors++;
      $display("FAIL R1: gate=%b busy=%b level=%0d expected 0110 0 1", gate, busy, leg_level);
    end
    run(2'd1, 4, "R2");
    run(2'd2, 8, "R4");        // 1->2 via SW2 only, deadtime 3 (R5)
    run(2'd1, 8, "R5");
    run(2'd0, 8, "R4");        // 1->0 via SW3 only
    run(2'd2, 16, "R6");       // 0->2 in two steps
    run(2'd3, 6, "R8");        // ignored
    run(2'd0, 1, "R7");
    run(2'd1, 1, "R7");        // arrives during 2->1 step
    run(2'd2, 1, "R7");
    run(2'd0, 20, "R7");       // latest wins
    @(negedge clk); dead_cycles = 8'd0;
    run(2'd1, 6, "R5");        // zero means one cycle
    @(negedge clk); dead_cycles = 8'd6;
    run(2'd2, 2, "R9");
    dead_cycles = 8'd1;        // change mid-step
    repeat (10) @(negedge clk);
    dead_cycles = 8'd2;
    run(2'd0, 14, "R6");
    run(2'd3, 4, "R8");
    rst = 1; tag = "R1";
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule